// File: doc/BRIEF.md
# Pseudo-SRAM Device-Side Mode Decoder

This block is the device-facing front end of a 16-bit pseudo-static RAM. On every clock edge it samples the memory pins: an active-low select, an active-high select, output enable, write enable and one active-low enable for each byte lane. From these it works out the operating mode. For a read it produces one output-drive control for each byte lane and the read word. For a write it produces byte-lane write strobes into an internal word array. The array is a small inferred store, organised in pages of four words.

Address bits above the lowest two select a page. The lowest two bits select a word within that page. All four words of the addressed page are fetched in parallel, so the host can step through the word-select bits on consecutive cycles and get one word per cycle.

A write takes effect when the internal write strobe ends, which is at the first release of either select or of write enable. The data, address and lane mask used are the values sampled in the last cycle the strobe was high. The pins are sampled as plain levels. There is no valid/ready handshake and no back-pressure: every sampled cycle is consumed. Each registered output reflects the pins sampled at the preceding clock edge.

Top module: `psr_front`

## Requirements
- R1: When the active-low select is high or the active-high select is low, the block reports mode code 0 (deselected), `standby_o` is 1, both drive controls are 0 and `rdata_o` is 0.
- R2: When selected with write enable high and output enable high, the block reports mode code 1 (output disabled), `standby_o` is 0 and both drive controls are 0.
- R3: When selected with write enable high and both byte enables high, the mode is 1 and both drive controls stay 0, even with output enable low.
- R4: When selected with output enable low, write enable high and at least one byte enable low, the mode is 2 (read). `drive_lo_o` equals the inverse of `lb_n_i` and `drive_hi_o` equals the inverse of `ub_n_i`. `rdata_o[7:0]` and `rdata_o[15:8]` carry the lower and upper byte of the addressed word when their lane is driven, and are 0 otherwise.
- R5: When selected with write enable low, the mode is 3 (write) whatever output enable is, and both drive controls are 0.
- R6: A write changes only the byte lanes whose enables are low: the lower byte `wdata_i[7:0]` when `lb_n_i` is low, and the upper byte `wdata_i[15:8]` when `ub_n_i` is low. A write with both byte enables high changes no stored data.
- R7: Stored data changes at the clock edge where the write strobe is first seen low, whether it ends by a select release or by write enable rising. The data used are those sampled in the strobe's last cycle. A read sampled at that same edge returns the new data.
- R8: `addr_i[ADDR_W-1:2]` selects a page and `addr_i[1:0]` selects one of its four words. Consecutive reads that change only the word bits each return their word one cycle after sampling.
- R9: In reset the mode is 0, `standby_o` is 1, the drive controls are 0 and `rdata_o` is 0. Outside reset, all outputs follow the pins sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Active-low device select |
| sel_i | input | 1 | Active-high device select |
| oe_n_i | input | 1 | Active-low output enable |
| we_n_i | input | 1 | Active-low write enable |
| lb_n_i | input | 1 | Active-low lower byte enable (data bits 7..0) |
| ub_n_i | input | 1 | Active-low upper byte enable (data bits 15..8) |
| addr_i | input | ADDR_W | Word address; bits 1..0 pick the word within a page |
| wdata_i | input | 2*LANE_W | Write data |
| rdata_o | output | 2*LANE_W | Registered read word, undriven lanes zero |
| drive_lo_o | output | 1 | Drive request for the lower data byte |
| drive_hi_o | output | 1 | Drive request for the upper data byte |
| mode_o | output | 2 | Mode: 0 deselected, 1 output disabled, 2 read, 3 write |
| standby_o | output | 1 | 1 in standby, 0 when active |

## Verification
On every cycle, the assertions check the mapping from sampled pins to mode, standby flag and per-lane drive controls. This covers deselection, output-disabled with both byte enables high, reads with each lane, and writes that keep both lanes quiet. Some behaviour can only be shown by the bench's scenarios, because it needs the stored contents. This includes byte-masked storage, the commit taking the last sampled write data, the forwarding of a write to a read in the cycle the strobe ends, and word-by-word page reads.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL  = 2'd0,
    MODE_OUTOFF = 2'd1,
    MODE_READ   = 2'd2,
    MODE_WRITE  = 2'd3
  } psr_mode_e;
endpackage

// File: rtl/psr_mode_decode.sv
module psr_mode_decode
  import psr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_n_i,
  input  logic             sel_i,
  input  logic             oe_n_i,
  input  logic             we_n_i,
  input  logic [LANES-1:0] be_n_i,
  output psr_mode_e        mode_o,
  output logic [LANES-1:0] rd_lane_o,
  output logic [LANES-1:0] wr_lane_o
);
  logic chosen;
  logic any_lane;

  assign chosen   = !sel_n_i && sel_i;
  assign any_lane = ~&be_n_i;

  // Priority: selection, then write enable, then output enable with a lane.
  always_comb begin
    if (!chosen)                  mode_o = MODE_DESEL;
    else if (!we_n_i)             mode_o = MODE_WRITE;
    else if (!oe_n_i && any_lane) mode_o = MODE_READ;
    else                          mode_o = MODE_OUTOFF;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_lane_o[g] = (mode_o == MODE_READ)  && !be_n_i[g];
    assign wr_lane_o[g] = (mode_o == MODE_WRITE) && !be_n_i[g];
  end
endmodule

// File: rtl/psr_write_capture.sv
module psr_write_capture #(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] wr_lane_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  output logic             commit_o,
  output logic [AW-1:0]    cap_addr_o,
  output logic [DW-1:0]    cap_data_o,
  output logic [LANES-1:0] cap_mask_o
);
  logic strobe;
  logic strb_q;

  assign strobe = |wr_lane_i;

  // Hold the most recent sample taken while the strobe is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q     <= 1'b0;
      cap_addr_o <= '0;
      cap_data_o <= '0;
      cap_mask_o <= '0;
    end else begin
      strb_q <= strobe;
      if (strobe) begin
        cap_addr_o <= addr_i;
        cap_data_o <= data_i;
        cap_mask_o <= wr_lane_i;
      end
    end
  end

  // The strobe's trailing edge is the commit point.
  assign commit_o = strb_q && !strobe;
endmodule

// File: rtl/psr_page_array.sv
module psr_page_array #(
  parameter int AW         = 6,
  parameter int LANE_W     = 8,
  parameter int LANES      = 2,
  parameter int PAGE_WORDS = 4
) (
  input  logic                    clk,
  input  logic                    commit_i,
  input  logic [AW-1:0]           cap_addr_i,
  input  logic [LANES*LANE_W-1:0] cap_data_i,
  input  logic [LANES-1:0]        cap_mask_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [LANES*LANE_W-1:0] rd_word_o
);
  localparam int COL_W = $clog2(PAGE_WORDS);
  localparam int ROW_W = AW - COL_W;
  localparam int ROWS  = 1 << ROW_W;

  typedef logic [PAGE_WORDS-1:0][LANES-1:0][LANE_W-1:0] page_t;

  page_t store_q [ROWS];
  page_t page_w;

  logic [ROW_W-1:0] wr_row, rd_row;
  logic [COL_W-1:0] wr_col, rd_col;

  assign wr_row = cap_addr_i[AW-1:COL_W];
  assign wr_col = cap_addr_i[COL_W-1:0];
  assign rd_row = rd_addr_i[AW-1:COL_W];
  assign rd_col = rd_addr_i[COL_W-1:0];

  always_ff @(posedge clk) begin
    if (commit_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (cap_mask_i[l])
          store_q[wr_row][wr_col][l] <= cap_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  // Whole-page fetch, with the committing write forwarded lane by lane.
  for (genvar w = 0; w < PAGE_WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic hit;
      assign hit = commit_i && cap_mask_i[l] && (wr_row == rd_row)
                   && (wr_col == COL_W'(w));
      assign page_w[w][l] = hit ? cap_data_i[l*LANE_W +: LANE_W]
                                : store_q[rd_row][w][l];
    end
  end

  assign rd_word_o = page_w[rd_col];
endmodule

// File: rtl/psr_front.sv
module psr_front
  import psr_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANE_W     = 8,
  parameter int PAGE_WORDS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel_n_i,
  input  logic                  sel_i,
  input  logic                  oe_n_i,
  input  logic                  we_n_i,
  input  logic                  lb_n_i,
  input  logic                  ub_n_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [2*LANE_W-1:0]   wdata_i,
  output logic [2*LANE_W-1:0]   rdata_o,
  output logic                  drive_lo_o,
  output logic                  drive_hi_o,
  output logic [1:0]            mode_o,
  output logic                  standby_o
);
  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  psr_mode_e         mode;
  logic [LANES-1:0]  be_n, rd_lane, wr_lane;
  logic              commit;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data, rd_word;
  logic [LANES-1:0]  cap_mask;

  psr_mode_e         mode_q;
  logic              standby_q;
  logic [LANES-1:0]  drive_q;
  logic [DATA_W-1:0] rdata_q;

  assign be_n = {ub_n_i, lb_n_i};

  psr_mode_decode #(.LANES(LANES)) u_dec (
    .sel_n_i   (sel_n_i),
    .sel_i     (sel_i),
    .oe_n_i    (oe_n_i),
    .we_n_i    (we_n_i),
    .be_n_i    (be_n),
    .mode_o    (mode),
    .rd_lane_o (rd_lane),
    .wr_lane_o (wr_lane)
  );

  psr_write_capture #(.AW(ADDR_W), .DW(DATA_W), .LANES(LANES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_lane_i  (wr_lane),
    .addr_i     (addr_i),
    .data_i     (wdata_i),
    .commit_o   (commit),
    .cap_addr_o (cap_addr),
    .cap_data_o (cap_data),
    .cap_mask_o (cap_mask)
  );

  psr_page_array #(
    .AW(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .PAGE_WORDS(PAGE_WORDS)
  ) u_arr (
    .clk        (clk),
    .commit_i   (commit),
    .cap_addr_i (cap_addr),
    .cap_data_i (cap_data),
    .cap_mask_i (cap_mask),
    .rd_addr_i  (addr_i),
    .rd_word_o  (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MODE_DESEL;
      standby_q <= 1'b1;
      drive_q   <= '0;
      rdata_q   <= '0;
    end else begin
      mode_q    <= mode;
      standby_q <= (mode == MODE_DESEL);
      drive_q   <= rd_lane;
      for (int l = 0; l < LANES; l++)
        rdata_q[l*LANE_W +: LANE_W] <= rd_lane[l] ? rd_word[l*LANE_W +: LANE_W]
                                                  : '0;
    end
  end

  assign mode_o     = mode_q;
  assign standby_o  = standby_q;
  assign drive_lo_o = drive_q[0];
  assign drive_hi_o = drive_q[1];
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/psr_front_chk.sv
module psr_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n_i,
  input logic       sel_i,
  input logic       oe_n_i,
  input logic       we_n_i,
  input logic       lb_n_i,
  input logic       ub_n_i,
  input logic       drive_lo_o,
  input logic       drive_hi_o,
  input logic [1:0] mode_o,
  input logic       standby_o
);
  logic on;
  assign on = !sel_n_i && sel_i;

  a_r1_desel_standby: assert property (@(posedge clk) disable iff (!rst_n)
    (!on) |=> (standby_o && mode_o == 2'd0 && !drive_lo_o && !drive_hi_o));

  a_r2_output_off: assert property (@(posedge clk) disable iff (!rst_n)
    (on && we_n_i && oe_n_i) |=> (mode_o == 2'd1 && !standby_o
                                  && !drive_lo_o && !drive_hi_o));

  a_r3_no_lane_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (on && we_n_i && lb_n_i && ub_n_i) |=> (mode_o == 2'd1 && !drive_lo_o
                                            && !drive_hi_o));

  a_r4_lower_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (on && we_n_i && !oe_n_i) |=> (drive_lo_o == !$past(lb_n_i)
                                   && drive_hi_o == !$past(ub_n_i)));

  a_r5_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !we_n_i) |=> (mode_o == 2'd3 && !drive_lo_o && !drive_hi_o));

  a_r9_standby_matches_mode: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o == (mode_o == 2'd0));
endmodule

bind psr_front psr_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_n_i    (sel_n_i),
  .sel_i      (sel_i),
  .oe_n_i     (oe_n_i),
  .we_n_i     (we_n_i),
  .lb_n_i     (lb_n_i),
  .ub_n_i     (ub_n_i),
  .drive_lo_o (drive_lo_o),
  .drive_hi_o (drive_hi_o),
  .mode_o     (mode_o),
  .standby_o  (standby_o)
);

// File: tb/test_psr_front.sv
module test_psr_front;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic sel_n_i, sel_i, oe_n_i, we_n_i, lb_n_i, ub_n_i;
  logic [AW-1:0] addr_i;
  logic [15:0] wdata_i, rdata_o;
  logic drive_lo_o, drive_hi_o, standby_o;
  logic [1:0] mode_o;

  psr_front i_psr_front (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n_i), .sel_i(sel_i),
    .oe_n_i(oe_n_i), .we_n_i(we_n_i), .lb_n_i(lb_n_i), .ub_n_i(ub_n_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .drive_lo_o(drive_lo_o), .drive_hi_o(drive_hi_o),
    .mode_o(mode_o), .standby_o(standby_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mdl [64];
  logic        p_strb = 1'b0;
  logic [AW-1:0] p_addr;
  logic [15:0] p_data;
  logic [1:0]  p_mask;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pins(input logic sn, input logic s, input logic oe, input logic we,
                      input logic lb, input logic ub, input logic [AW-1:0] a,
                      input logic [15:0] d);
    sel_n_i = sn; sel_i = s; oe_n_i = oe; we_n_i = we;
    lb_n_i = lb; ub_n_i = ub; addr_i = a; wdata_i = d;
  endtask

  // One sampled cycle; outputs are checked against the requirement model.
  task automatic step();
    logic on, wr, rd, strb;
    logic [1:0] msk, m, drv;
    logic [15:0] exp_rd;
    string tag;
    on   = !sel_n_i && sel_i;
    wr   = on && !we_n_i;
    msk  = wr ? ~{ub_n_i, lb_n_i} : 2'b00;
    strb = |msk;
    rd   = on && we_n_i && !oe_n_i && !(lb_n_i && ub_n_i);
    @(posedge clk);
    if (p_strb && !strb) begin
      if (p_mask[0]) mdl[p_addr][7:0]  = p_data[7:0];
      if (p_mask[1]) mdl[p_addr][15:8] = p_data[15:8];
    end
    if (strb) begin p_addr = addr_i; p_data = wdata_i; p_mask = msk; end
    p_strb = strb;
    if (!on)      begin m = 2'd0; tag = "R1"; end
    else if (wr)  begin m = 2'd3; tag = "R5"; end
    else if (rd)  begin m = 2'd2; tag = "R4"; end
    else          begin m = 2'd1; tag = (!oe_n_i) ? "R3" : "R2"; end
    drv = rd ? ~{ub_n_i, lb_n_i} : 2'b00;
    exp_rd = {drv[1] ? mdl[addr_i][15:8] : 8'h00, drv[0] ? mdl[addr_i][7:0] : 8'h00};
    #1;
    check(tag, {11'd0, mode_o, standby_o, drive_hi_o, drive_lo_o, rdata_o},
               {11'd0, m, (m == 2'd0), drv, exp_rd});
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d,
                            input logic lb, input logic ub);
    pins(1'b0, 1'b1, 1'b1, 1'b0, lb, ub, a, d); step();
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, a, 16'h0); step();
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [15:0] q);
    pins(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, a, 16'h0); step();
    q = rdata_o;
  endtask

  function automatic logic [15:0] fill_val(input int a);
    return 16'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] q, old;
    rst_n = 1'b0;
    pins(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check("R9", {11'd0, mode_o, standby_o, drive_hi_o, drive_lo_o, rdata_o},
                {11'd0, 2'd0, 1'b1, 2'b00, 16'h0000});
    @(negedge clk);
    rst_n = 1'b1;

    // Fill every word (R5/R2 checked per step)
    for (int a = 0; a < 64; a++) write_word(AW'(a), fill_val(a), 1'b0, 1'b0);
    for (int a = 0; a < 64; a += 9) begin
      read_word(AW'(a), q);
      check("R4", {16'd0, q}, {16'd0, fill_val(a)});
    end

    // Exhaustive sweep of all 64 control-pin combinations (R1..R5)
    for (int v = 0; v < 64; v++) begin
      logic [5:0] pv;
      pv = 6'(v);
      pins(pv[5], pv[4], pv[3], pv[2], pv[1], pv[0], AW'(v * 7), 16'(v * 997));
      step();
    end
    pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0); step();

    // R6: lane-masked writes
    read_word(6'd5, old);
    write_word(6'd5, 16'hAAAA, 1'b0, 1'b1);
    read_word(6'd5, q);
    check("R6", {16'd0, q}, {16'd0, old[15:8], 8'hAA});
    write_word(6'd5, 16'h5555, 1'b1, 1'b0);
    read_word(6'd5, q);
    check("R6", {16'd0, q}, {16'd0, 16'h55AA});
    write_word(6'd5, 16'h1234, 1'b1, 1'b1);
    read_word(6'd5, q);
    check("R6", {16'd0, q}, {16'd0, 16'h55AA});

    // R7: multi-cycle write ended by select release; last sample wins
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9, 16'h1111); step();
    pins(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'd9, 16'h2222); step();
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd9, 16'h3333); step();
    pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'd9, 16'h4444); step();
    read_word(6'd9, q);
    check("R7", {16'd0, q}, {16'd0, 16'h3333});
    // R7: write ended by write enable rising, read in the same cycle
    pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 6'd10, 16'hBEEF); step();
    read_word(6'd10, q);
    check("R7", {16'd0, q}, {16'd0, 16'hBEEF});

    // R8: page reads, word bits only change on consecutive cycles
    for (int w = 0; w < 4; w++)
      write_word(AW'(28 + w), 16'hC0DE ^ 16'(w * 16'h1111), 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      int w;
      w = (k * 3 + 2) % 4;
      read_word(AW'(28 + w), q);
      check("R8", {16'd0, q}, {16'd0, 16'hC0DE ^ 16'(w * 16'h1111)});
    end
    read_word(6'd24, q);
    check("R8", {16'd0, q}, {16'd0, mdl[24]});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule